// File: doc/BRIEF.md
# Digital Phase-Frequency Detector with Lock Indication

This block compares two divided clocks, a reference `ref_div_i` and a feedback `fb_div_i`, both sampled on the system clock, and produces the two steering enables that drive a charge pump. A rising edge on the reference raises an "advance" flag, and a rising edge on the feedback raises a "retard" flag. As soon as both flags would be set together, both are cleared. Edges that arrive in the same cycle therefore cancel, and an aligned loop leaves the pump undriven.

A single sense input does two jobs. It picks the steering polarity, so the advance flag drives either the up or the down enable. It also picks which divided clock appears on a monitor output. A lock indicator idles high and goes low only while exactly one flag is pending. An active-low power-down input forces the pump into high impedance at once, and the flags are cleared on the next clock.

Top module: `phase_lock_detector`

## Requirements
- R1: With `sense_i`=1 and `pwr_on_ni`=1, a rising edge of `ref_div_i` is sampled on a clock edge when no feedback edge and no retard flag are present. After that edge, `pump_up_o` is 1 and `pump_dn_o` is 0.
- R2: With `sense_i`=1 and `pwr_on_ni`=1, a rising edge of `fb_div_i` is sampled when no reference edge and no advance flag are present. After that edge, `pump_dn_o` is 1 and `pump_up_o` is 0.
- R3: When the edge that would set one flag is sampled while the other flag is pending, both flags are clear after that clock edge. This also applies when both edges are sampled in the same cycle. The two flags are never set together.
- R4: With `sense_i`=0, the advance flag drives `pump_dn_o` and the retard flag drives `pump_up_o`.
- R5: `mon_o` equals `ref_div_i` when `sense_i`=1 and equals `fb_div_i` when `sense_i`=0, with no clock delay.
- R6: `lock_o` is 0 exactly while one flag is pending and power is on. Otherwise it is 1.
- R7: While `pwr_on_ni`=0, `pump_up_o` and `pump_dn_o` are 0, `pump_hiz_o` is 1 and `lock_o` is 1, with no clock delay. Both flags are clear after the next clock edge.
- R8: `pump_hiz_o` is 0 exactly when `pump_up_o` or `pump_dn_o` is 1.
- R9: After reset (`rst_ni`=0), both flags are clear. The pump enables are 0, `pump_hiz_o` is 1 and `lock_o` is 1.
- R10: Further rising edges on the same input while its own flag is pending leave that flag set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ref_div_i | input | 1 | Reference divider output |
| fb_div_i | input | 1 | Feedback divider output |
| sense_i | input | 1 | 1 = normal polarity and reference monitored; 0 = swapped polarity and feedback monitored |
| pwr_on_ni | input | 1 | Power-down, active low |
| pump_up_o | output | 1 | Charge-pump source enable |
| pump_dn_o | output | 1 | Charge-pump sink enable |
| pump_hiz_o | output | 1 | 1 = pump in high impedance |
| lock_o | output | 1 | Lock indicator, low only while a phase error is pending |
| mon_o | output | 1 | Monitor of the selected divided clock |

## Verification
The bench targets three corner cases:
- Edges on both inputs in the same cycle must cancel. A detector that let one input win would leave a lone flag set and pull `lock_o` low on an aligned loop.
- A second edge on an input whose flag is already pending must not disturb that flag. A design that toggled or cleared it would lose frequency steering.
- Dropping power while a flag is pending must release the pump in that same cycle and must keep the stale flag from reappearing when power returns.

It also swaps polarity while an error is pending, which shows whether the sense input swaps the enables or only the monitor. Many cycles of pseudo-random edges compare every output against a behavioural model.

// File: rtl/pfd_pkg.sv
package pfd_pkg;
  localparam int unsigned NUM_CH = 2;
  localparam int unsigned CH_REF = 0;
  localparam int unsigned CH_FB  = 1;

  typedef struct packed {
    logic adv;
    logic ret;
  } pfd_flags_t;

  // Next flag state: set on own edge, both cleared once both would be set.
  function automatic pfd_flags_t pfd_next(pfd_flags_t cur, logic ref_edge, logic fb_edge);
    pfd_flags_t n;
    n.adv = cur.adv | ref_edge;
    n.ret = cur.ret | fb_edge;
    if (n.adv && n.ret) begin
      n = '0;
    end
    return n;
  endfunction
endpackage

// File: rtl/pfd_edge_detect.sv
module pfd_edge_detect #(
  parameter int unsigned WIDTH = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] sig_i,
  output logic [WIDTH-1:0] rise_o
);
  logic [WIDTH-1:0] prev_q;

  for (genvar g = 0; g < WIDTH; g++) begin : g_ch
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) prev_q[g] <= 1'b0;
      else         prev_q[g] <= sig_i[g];
    end
    assign rise_o[g] = sig_i[g] & ~prev_q[g];
  end
endmodule

// File: rtl/pfd_flag_core.sv
module pfd_flag_core
  import pfd_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       pwr_on_ni,
  input  logic       ref_edge_i,
  input  logic       fb_edge_i,
  output pfd_flags_t flags_o
);
  pfd_flags_t flags_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         flags_q <= '0;
    else if (!pwr_on_ni) flags_q <= '0;
    else                 flags_q <= pfd_next(flags_q, ref_edge_i, fb_edge_i);
  end

  assign flags_o = flags_q;
endmodule

// File: rtl/pfd_output_stage.sv
module pfd_output_stage
  import pfd_pkg::*;
(
  input  pfd_flags_t flags_i,
  input  logic       sense_i,
  input  logic       pwr_on_ni,
  input  logic       ref_div_i,
  input  logic       fb_div_i,
  output logic       pump_up_o,
  output logic       pump_dn_o,
  output logic       pump_hiz_o,
  output logic       lock_o,
  output logic       mon_o
);
  logic up_raw, dn_raw, err_one;

  always_comb begin
    up_raw = sense_i ? flags_i.adv : flags_i.ret;
    dn_raw = sense_i ? flags_i.ret : flags_i.adv;
    pump_up_o  = pwr_on_ni & up_raw;
    pump_dn_o  = pwr_on_ni & dn_raw;
    pump_hiz_o = ~(pwr_on_ni & (flags_i.adv | flags_i.ret));
    err_one    = flags_i.adv ^ flags_i.ret;
    lock_o     = ~(pwr_on_ni & err_one);
    mon_o      = sense_i ? ref_div_i : fb_div_i;
  end
endmodule

// File: rtl/phase_lock_detector.sv
module phase_lock_detector
  import pfd_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic ref_div_i,
  input  logic fb_div_i,
  input  logic sense_i,
  input  logic pwr_on_ni,
  output logic pump_up_o,
  output logic pump_dn_o,
  output logic pump_hiz_o,
  output logic lock_o,
  output logic mon_o
);
  logic [NUM_CH-1:0] rise;
  logic ref_rise, fb_rise;
  logic adv_flag, ret_flag;
  pfd_flags_t flags;

  pfd_edge_detect #(.WIDTH(NUM_CH)) u_edge (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .sig_i  ({fb_div_i, ref_div_i}),
    .rise_o (rise)
  );

  assign ref_rise = rise[CH_REF];
  assign fb_rise  = rise[CH_FB];

  pfd_flag_core u_core (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .pwr_on_ni  (pwr_on_ni),
    .ref_edge_i (ref_rise),
    .fb_edge_i  (fb_rise),
    .flags_o    (flags)
  );

  assign adv_flag = flags.adv;
  assign ret_flag = flags.ret;

  pfd_output_stage u_out (
    .flags_i    (flags),
    .sense_i    (sense_i),
    .pwr_on_ni  (pwr_on_ni),
    .ref_div_i  (ref_div_i),
    .fb_div_i   (fb_div_i),
    .pump_up_o  (pump_up_o),
    .pump_dn_o  (pump_dn_o),
    .pump_hiz_o (pump_hiz_o),
    .lock_o     (lock_o),
    .mon_o      (mon_o)
  );
endmodule

// File: rtl/phase_lock_detector_chk.sv
module phase_lock_detector_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic pwr_on_ni,
  input logic pump_up_o,
  input logic pump_dn_o,
  input logic pump_hiz_o,
  input logic lock_o,
  input logic ref_rise,
  input logic fb_rise,
  input logic adv_flag,
  input logic ret_flag
);
  // R1
  adv_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pwr_on_ni && ref_rise && !fb_rise && !ret_flag) |=> adv_flag);

  // R2
  ret_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pwr_on_ni && fb_rise && !ref_rise && !adv_flag) |=> ret_flag);

  // R3
  cancel_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pwr_on_ni && adv_flag && fb_rise) |=> (!adv_flag && !ret_flag));

  // R3
  flags_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({adv_flag, ret_flag}));

  // R7
  pwrdn_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pwr_on_ni |-> (!pump_up_o && !pump_dn_o && pump_hiz_o && lock_o));

  // R7
  pwrdn_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pwr_on_ni |=> (!adv_flag && !ret_flag));

  // R8
  hiz_drive_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pump_hiz_o == !(pump_up_o || pump_dn_o));

  // R6
  lock_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !lock_o |-> (pump_up_o ^ pump_dn_o));

  // R10
  hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pwr_on_ni && adv_flag && !fb_rise) |=> adv_flag);
endmodule

bind phase_lock_detector phase_lock_detector_chk u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .pwr_on_ni  (pwr_on_ni),
  .pump_up_o  (pump_up_o),
  .pump_dn_o  (pump_dn_o),
  .pump_hiz_o (pump_hiz_o),
  .lock_o     (lock_o),
  .ref_rise   (ref_rise),
  .fb_rise    (fb_rise),
  .adv_flag   (adv_flag),
  .ret_flag   (ret_flag)
);

// File: tb/phase_lock_detector_bench.sv
`timescale 1ns/1ps
module phase_lock_detector_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic fr = 1'b0, fp = 1'b0, sense = 1'b1, pwr = 1'b1;
  logic up, dn, hiz, lock, mon;
  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #5 clk = ~clk;

  phase_lock_detector u_phase_lock_detector (
    .clk_i(clk), .rst_ni(rst_n), .ref_div_i(fr), .fb_div_i(fp),
    .sense_i(sense), .pwr_on_ni(pwr),
    .pump_up_o(up), .pump_dn_o(dn), .pump_hiz_o(hiz),
    .lock_o(lock), .mon_o(mon)
  );

  // Behavioural model: integers for pending error direction.
  int m_err;       // +1 reference ahead, -1 feedback ahead, 0 none
  int m_pfr, m_pfp;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_err = 0; m_pfr = 0; m_pfp = 0;
    end else begin
      int er, ef;
      er = (fr == 1'b1 && m_pfr == 0) ? 1 : 0;
      ef = (fp == 1'b1 && m_pfp == 0) ? 1 : 0;
      if (pwr == 1'b0) m_err = 0;
      else if (er == 1 && ef == 1) m_err = 0;
      else if (er == 1) m_err = (m_err == -1) ? 0 : 1;
      else if (ef == 1) m_err = (m_err == 1) ? 0 : -1;
      m_pfr = fr; m_pfp = fp;
    end
  end

  task automatic chk(input string tag, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %b expected %b at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && !done) begin
      logic eu, ed, src, snk;
      src = (m_err == 1); snk = (m_err == -1);
      eu = pwr && (sense ? src : snk);
      ed = pwr && (sense ? snk : src);
      chk("R1 R4 pump_up model", up, eu);
      chk("R2 R4 pump_dn model", dn, ed);
      chk("R8 hiz model", hiz, !(pwr && m_err != 0));
      chk("R6 lock model", lock, !(pwr && m_err != 0));
      chk("R5 mon model", mon, sense ? fr : fp);
    end
  end

  task automatic step(input logic a, input logic b);
    @(posedge clk); #2; fr = a; fp = b;
    @(negedge clk); #1;
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual hung expected finish");
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R9 up after reset", up, 1'b0);
    chk("R9 dn after reset", dn, 1'b0);
    chk("R9 hiz after reset", hiz, 1'b1);
    chk("R9 lock after reset", lock, 1'b1);
    @(posedge clk); #2; rst_n = 1'b1;
    step(0,0);
    step(1,0); step(0,0);
    chk("R1 up after ref edge", up, 1'b1);
    chk("R6 lock low on error", lock, 1'b0);
    chk("R8 hiz low while driving", hiz, 1'b0);
    step(1,0); step(0,0);
    chk("R10 up held on second ref edge", up, 1'b1);
    step(0,1); step(0,0);
    chk("R3 up cleared by fb edge", up, 1'b0);
    chk("R3 dn not set", dn, 1'b0);
    step(0,1); step(0,0);
    chk("R2 dn after fb edge", dn, 1'b1);
    step(1,0); step(0,0);
    chk("R3 dn cleared", dn, 1'b0);
    step(1,1); step(0,0);
    chk("R3 simultaneous up", up, 1'b0);
    chk("R3 simultaneous dn", dn, 1'b0);
    chk("R3 simultaneous lock", lock, 1'b1);
    sense = 1'b0;
    step(1,0); step(0,0);
    chk("R4 swapped dn", dn, 1'b1);
    chk("R4 swapped up", up, 1'b0);
    step(0,1); step(1,0);
    chk("R5 mon follows fb", mon, 1'b0);
    sense = 1'b1; #1;
    chk("R5 mon follows ref", mon, 1'b1);
    step(0,0); step(0,0);
    step(1,0); step(0,0);
    chk("R1 up before power-down", up, 1'b1);
    pwr = 1'b0; #1;
    chk("R7 up gated", up, 1'b0);
    chk("R7 hiz forced", hiz, 1'b1);
    chk("R7 lock high", lock, 1'b1);
    step(0,0);
    pwr = 1'b1; #1;
    chk("R7 flag cleared up", up, 1'b0);
    chk("R7 flag cleared hiz", hiz, 1'b1);
    for (int i = 0; i < 4000; i++) begin
      logic a, b;
      a = $urandom_range(0, 1); b = $urandom_range(0, 1);
      if ($urandom_range(0, 15) == 0) sense = ~sense;
      pwr = ($urandom_range(0, 31) != 0);
      step(a, b);
    end
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule